// File: doc/BRIEF.md
# Beep Activity Wake Monitor

This block keeps the speaker and headphone amplifier enables off while the audio function sits in its deepest software-visible low-power state (D3 hot). It turns them on only when a tone appears on a single-bit beep line. The line can rest at either logic level, so the monitor never reads its level. It counts transitions after a two-flop synchronizer. A programmable number of transitions inside a programmable window declares activity, and the enables come up a fixed three clocks after the deciding transition. An inactivity timer is reloaded on every transition and drops the enables after a programmable hold time. A sticky wake flag records that a wake took place until it is cleared.

In the full-power states D0 to D2 the enables pass the normal amplifier requests through unchanged, and the monitor stays idle. In the states beyond D3 hot (D3 cold, the two vendor-specific deeper states, and the reserved code) the enables are forced low and the monitor is idle.

Top module: `beep_wake_monitor`

## Requirements
- R1: While reset is asserted and right after it is released, `spk_en`, `hp_en`, `active` and `wake_flag` are 0.
- R2: The resting level of `beep_in` at reset, whether 0 or 1, never counts as a transition. Rising and falling transitions count alike.
- R3: In D3 hot (`pwr_state` = 3), `active` rises at the third rising clock edge after the `beep_in` transition that brings the count to `edge_thr`. An `edge_thr` of 0 behaves as 1.
- R4: The first counted transition opens a window of `win_len` clocks. If the window closes before `edge_thr` transitions are counted, the count is discarded and no activity is declared.
- R5: Once `active` is high, each counted transition reloads the hold timer. `active` falls exactly `hold_len` clocks after the last counted transition. A `hold_len` of 0 behaves as 1.
- R6: In D3 hot, `spk_en` and `hp_en` both equal `active`, and `spk_req` and `hp_req` have no effect.
- R7: For `pwr_state` 0, 1 or 2, `spk_en` equals `spk_req` and `hp_en` equals `hp_req` in the same cycle. Transitions are ignored, and `active` is 0 from the clock after `pwr_state` leaves 3.
- R8: For `pwr_state` 4 to 7 (D3 cold, D4, D5, reserved), `spk_en` and `hp_en` are 0 and transitions never raise `active`.
- R9: `wake_flag` is set in the cycle `active` rises and stays set until a clock with `sticky_clr` high. A wake in the same clock as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beep_in | input | 1 | Asynchronous beep line, either idle level |
| pwr_state | input | 3 | Power state: 0-2 D0-D2, 3 D3 hot, 4 D3 cold, 5 D4, 6 D5, 7 reserved |
| spk_req | input | 1 | Normal speaker amplifier enable request |
| hp_req | input | 1 | Normal headphone amplifier enable request |
| win_len | input | WIN_W | Detection window length in clocks |
| edge_thr | input | THR_W | Transitions needed inside the window |
| hold_len | input | HOLD_W | Clocks to stay on after the last transition |
| sticky_clr | input | 1 | Clears `wake_flag` |
| spk_en | output | 1 | Speaker amplifier enable |
| hp_en | output | 1 | Headphone amplifier enable |
| active | output | 1 | Tone activity detected |
| wake_flag | output | 1 | Sticky record of a wake |

## Verification
A transition driven on `beep_in` between clock edges passes two synchronizer flops and one registered decision, so `active` and the D3 enables are due just after the third rising edge. The bench samples one clock before that point and again at it. The fall of `active` is checked at the clock before and the clock of the `hold_len`-th edge after the last counted transition. The enables in the other power states are combinational and are checked one time step after `pwr_state` or the requests change. The clear of `active` on leaving D3 is checked after one edge.

// File: rtl/beep_wake_monitor.sv
module beep_wake_monitor #(
  parameter int WIN_W  = 16,
  parameter int THR_W  = 4,
  parameter int HOLD_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beep_in,
  input  logic [2:0]        pwr_state,
  input  logic              spk_req,
  input  logic              hp_req,
  input  logic [WIN_W-1:0]  win_len,
  input  logic [THR_W-1:0]  edge_thr,
  input  logic [HOLD_W-1:0] hold_len,
  input  logic              sticky_clr,
  output logic              spk_en,
  output logic              hp_en,
  output logic              active,
  output logic              wake_flag
);
  localparam logic [2:0] PS_D3 = 3'd3;

  logic [2:0]        sync_q;
  logic [1:0]        prime_q;
  logic [THR_W-1:0]  ecnt_q;
  logic [WIN_W-1:0]  wtim_q;
  logic [HOLD_W-1:0] htim_q;
  logic              active_q;
  logic              wake_q;

  wire ready     = &prime_q;
  wire run       = (pwr_state == PS_D3);
  wire normal    = (pwr_state < PS_D3);
  wire edge_seen = ready & (sync_q[1] ^ sync_q[2]);
  wire win_open  = (wtim_q != '0);

  wire [THR_W-1:0]  thr_eff  = (edge_thr == '0) ? THR_W'(1) : edge_thr;
  wire [HOLD_W-1:0] hold_eff = (hold_len == '0) ? HOLD_W'(1) : hold_len;
  wire [THR_W-1:0]  cnt_next = win_open ? ecnt_q + THR_W'(1) : THR_W'(1);
  wire              hit      = run & ~active_q & edge_seen & (cnt_next >= thr_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '0;
      prime_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], beep_in};
      if (!ready) prime_q <= prime_q + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      active_q <= 1'b0;
      ecnt_q   <= '0;
      wtim_q   <= '0;
      htim_q   <= '0;
    end else if (active_q) begin
      if (edge_seen) begin
        htim_q <= hold_eff;
      end else if (htim_q == HOLD_W'(1)) begin
        active_q <= 1'b0;
        htim_q   <= '0;
      end else begin
        htim_q <= htim_q - HOLD_W'(1);
      end
    end else if (hit) begin
      active_q <= 1'b1;
      htim_q   <= hold_eff;
      ecnt_q   <= '0;
      wtim_q   <= '0;
    end else if (edge_seen) begin
      ecnt_q <= cnt_next;
      wtim_q <= win_open ? wtim_q - WIN_W'(1) : win_len;
    end else if (win_open) begin
      wtim_q <= wtim_q - WIN_W'(1);
      if (wtim_q == WIN_W'(1)) ecnt_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          wake_q <= 1'b0;
    else if (hit)        wake_q <= 1'b1;
    else if (sticky_clr) wake_q <= 1'b0;
  end

  assign active    = active_q;
  assign wake_flag = wake_q;
  assign spk_en    = normal ? spk_req : (run & active_q);
  assign hp_en     = normal ? hp_req  : (run & active_q);
endmodule

module beep_wake_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] pwr_state,
  input logic       spk_req,
  input logic       hp_req,
  input logic       sticky_clr,
  input logic       spk_en,
  input logic       hp_en,
  input logic       active,
  input logic       wake_flag
);
  // R8
  deep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state >= 3'd4 |-> (!spk_en && !hp_en));
  // R6
  d3_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == 3'd3 |-> (spk_en == active && hp_en == active));
  // R7
  normal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state < 3'd3 |-> (spk_en == spk_req && hp_en == hp_req));
  // R7
  idle_outside_d3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state != 3'd3 |=> !active);
  // R9
  wake_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> wake_flag);
  // R9
  wake_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_flag && !sticky_clr) |=> wake_flag);
endmodule

bind beep_wake_monitor beep_wake_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state), .spk_req(spk_req),
  .hp_req(hp_req), .sticky_clr(sticky_clr), .spk_en(spk_en), .hp_en(hp_en),
  .active(active), .wake_flag(wake_flag)
);

// File: tb/beep_wake_monitor_test.sv
module beep_wake_monitor_test;
  localparam int HOLD = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        beep = 1'b1;
  logic [2:0]  pwr = 3'd3;
  logic        spk_req = 1'b0, hp_req = 1'b0, sticky_clr = 1'b0;
  logic [15:0] win_len = 16'd8;
  logic [3:0]  edge_thr = 4'd1;
  logic [19:0] hold_len = 20'(HOLD);
  logic        spk_en, hp_en, active, wake_flag;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  beep_wake_monitor uut (
    .clk(clk), .rst_n(rst_n), .beep_in(beep), .pwr_state(pwr),
    .spk_req(spk_req), .hp_req(hp_req), .win_len(win_len),
    .edge_thr(edge_thr), .hold_len(hold_len), .sticky_clr(sticky_clr),
    .spk_en(spk_en), .hp_en(hp_en), .active(active), .wake_flag(wake_flag)
  );

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic flip();
    beep = ~beep;
  endtask

  task automatic wake_up();
    flip(); step(3);
    flip(); step(2);
    chk("R3 not yet active", active, 0);
    step(1);
    chk("R3 active after third edge", active, 1);
  endtask

  task automatic t_reset();
    chk("R1 spk_en reset", spk_en, 0);
    chk("R1 hp_en reset", hp_en, 0);
    chk("R1 active reset", active, 0);
    chk("R1 wake reset", wake_flag, 0);
    step(10);
    chk("R2 idle high not an edge", active, 0);
  endtask

  task automatic t_activate();
    edge_thr = 4'd2; spk_req = 1'b1; hp_req = 1'b1; step(1);
    chk("R6 req ignored in D3", spk_en, 0);
    flip(); step(3);
    chk("R3 one edge short", active, 0);
    flip(); step(2);
    chk("R3 not yet", active, 0);
    step(1);
    chk("R3 active", active, 1);
    chk("R6 spk_en follows active", spk_en, 1);
    chk("R6 hp_en follows active", hp_en, 1);
    chk("R9 wake set", wake_flag, 1);
    step(HOLD - 1);
    chk("R5 held before timeout", active, 1);
    step(1);
    chk("R5 dropped at timeout", active, 0);
    chk("R6 spk_en off with req high", spk_en, 0);
    chk("R9 wake persists", wake_flag, 1);
    sticky_clr = 1'b1; step(1); sticky_clr = 1'b0;
    chk("R9 wake cleared", wake_flag, 0);
  endtask

  task automatic t_hold();
    wake_up();
    for (int i = 0; i < 4; i++) begin
      step(8);
      chk("R5 extended by edges", active, 1);
      flip();
    end
    step(3 + HOLD - 1);
    chk("R5 held after last edge", active, 1);
    step(1);
    chk("R5 dropped after last edge", active, 0);
  endtask

  task automatic t_window();
    for (int i = 0; i < 3; i++) begin
      flip(); step(20);
      chk("R4 sparse edges no wake", active, 0);
    end
    step(20);
  endtask

  task automatic t_thr_zero();
    edge_thr = 4'd0;
    flip(); step(2);
    chk("R3 thr0 not yet", active, 0);
    step(1);
    chk("R3 thr0 single edge wakes", active, 1);
    step(HOLD);
    chk("R5 thr0 drop", active, 0);
    edge_thr = 4'd2;
  endtask

  task automatic t_normal();
    pwr = 3'd0; spk_req = 1'b1; hp_req = 1'b0; #1;
    chk("R7 spk pass D0", spk_en, 1);
    chk("R7 hp pass D0", hp_en, 0);
    for (int i = 0; i < 4; i++) begin flip(); step(2); end
    step(4);
    chk("R7 edges ignored D0", active, 0);
    pwr = 3'd2; spk_req = 1'b0; hp_req = 1'b1; #1;
    chk("R7 spk pass D2", spk_en, 0);
    chk("R7 hp pass D2", hp_en, 1);
    step(1);
  endtask

  task automatic t_deep();
    spk_req = 1'b1; hp_req = 1'b1;
    for (int p = 4; p < 8; p++) begin
      pwr = 3'(p); #1;
      chk("R8 spk off deep", spk_en, 0);
      chk("R8 hp off deep", hp_en, 0);
      for (int i = 0; i < 3; i++) begin flip(); step(2); end
      step(4);
      chk("R8 no wake deep", active, 0);
    end
    pwr = 3'd3; step(2);
  endtask

  task automatic t_exit();
    wake_up();
    pwr = 3'd1; spk_req = 1'b0; hp_req = 1'b1; #1;
    chk("R7 enables follow req on exit", spk_en, 0);
    chk("R7 hp follows req on exit", hp_en, 1);
    step(1);
    chk("R7 active cleared on exit", active, 0);
    pwr = 3'd3; step(2);
  endtask

  task automatic t_sticky_race();
    sticky_clr = 1'b1; step(1);
    chk("R9 cleared before race", wake_flag, 0);
    wake_up();
    chk("R9 set wins over clear", wake_flag, 1);
    step(1);
    chk("R9 clear after wake", wake_flag, 0);
    sticky_clr = 1'b0;
    step(HOLD + 2);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_activate();
    t_hold();
    t_window();
    t_thr_zero();
    t_normal();
    t_deep();
    t_exit();
    t_sticky_race();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule